// File: doc/BRIEF.md
# Nine-Channel Peripheral DMA Controller

The block moves data on behalf of a processor. Nine independent channels each run one one-way transfer: memory to memory, peripheral to memory, or memory to peripheral. Software programs a channel through a register port with a source address, a destination address, a beat count and a control word, and then sets the channel's enable bit. The engine then runs beats on a single simple bus-master port. Each beat is one read from the source, held in that channel's one-word staging register, followed by one write of that word to the destination.

A fixed-priority arbiter hands the bus to the lowest-numbered channel that is ready. A new choice is made only between beats. A peripheral channel is ready only while its request line is high, and it is acknowledged once per beat. When the count runs out, the channel raises a sticky done flag and clears its own enable. Software can poll the flag or use a per-channel interrupt line.

Top module: `dma_mover`

## Requirements
- R1: After reset every channel register reads zero, `bus_req_o` is low and all `irq_o` bits are low.
- R2: Once `bus_req_o` is high it stays high until `bus_ack_i`, and the address, write flag and size stay unchanged while it waits.
- R3: A register is addressed as {channel, select[2:0]}. Select 0 is control, 1 source, 2 destination, 3 count and 4 status. Control bits: [0] enable, [2:1] mode (0 memory-to-memory, 1 peripheral-to-memory, 2 memory-to-peripheral), [4:3] size (0 byte, 1 half-word, 2 word), [5] hold source, [6] hold destination, [7] interrupt enable. Control reads back as written, and channels that do not exist read zero.
- R4: A beat reads the source, keeps the read data masked to the size, and then writes that word to the destination with the same size. The write request starts the cycle after the read acknowledge.
- R5: When several channels are ready, the lowest index wins. The granted channel keeps the bus until its write is acknowledged.
- R6: After each beat, an address that is not held advances by 1, 2 or 4 for byte, half-word or word. A held address stays where it is.
- R7: A peripheral-mode channel starts beats only while its `periph_req_i` bit is high. Its `periph_ack_o` bit pulses for exactly one cycle per beat, in the cycle of the write acknowledge.
- R8: The count drops by one per beat. When an enabled channel is idle with a count of zero, status bit 0 (done) sets and the enable bit clears on the same edge. This also applies when the channel is enabled with a count of zero.
- R9: Clearing enable stops the channel after any beat already in flight. The count then stays where it is, and done stays low.
- R10: Writing 1 to status bit 0 clears done. `irq_o[n]` is high exactly while channel n has done set and interrupt enable set.
- R11: Reading source, destination and count returns the live values, so after completion they show the final addresses and zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | CH_W+3 | {channel, select} register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| periph_req_i | input | NUM_CH | Per-channel peripheral request |
| periph_ack_o | output | NUM_CH | Per-channel beat acknowledge |
| irq_o | output | NUM_CH | Per-channel interrupt |
| bus_req_o | output | 1 | Bus request |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_addr_o | output | ADDR_W | Byte address |
| bus_size_o | output | 2 | Access size code |
| bus_wdata_o | output | 32 | Write data |
| bus_rdata_i | input | 32 | Read data, valid with acknowledge |
| bus_ack_i | input | 1 | Access complete |

## Verification
Register reads are combinational, so the bench samples them 1 ns after it sets the address. An enable with a count of zero shows done and a cleared enable two edges after the write strobe is applied, and the bench reads both at the second falling edge after the strobe. A beat costs one idle cycle, a read request, the read acknowledge, a write request and the write acknowledge. For that reason the bench checks the first bus address one falling edge after it raises the peripheral requests, and checks that the request is held one edge later, when the model bus acknowledges. Transfers of variable length are awaited by polling the interrupt at falling edges against a cycle limit. The memory image is then compared with a copy the bench computes itself.

// File: rtl/dma_mover_pkg.sv
`timescale 1ns/1ps
package dma_mover_pkg;

  typedef enum logic [1:0] {
    XFER_M2M  = 2'd0,
    XFER_P2M  = 2'd1,
    XFER_M2P  = 2'd2,
    XFER_RSVD = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  // bit 0 = en ... bit 7 = irq_en
  typedef struct packed {
    logic       irq_en;
    logic       dst_hold;
    logic       src_hold;
    xfer_size_e size;
    xfer_mode_e mode;
    logic       en;
  } chan_cfg_t;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_READ  = 2'd1,
    ENG_WRITE = 2'd2
  } eng_state_e;

  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_SRC  = 3'd1;
  localparam logic [2:0] SEL_DST  = 3'd2;
  localparam logic [2:0] SEL_CNT  = 3'd3;
  localparam logic [2:0] SEL_STAT = 3'd4;

  function automatic logic [2:0] size_step(xfer_size_e s);
    case (s)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] size_mask(xfer_size_e s);
    case (s)
      SZ_BYTE: return 32'h0000_00ff;
      SZ_HALF: return 32'h0000_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction

  function automatic logic needs_req(xfer_mode_e m);
    return (m == XFER_P2M) || (m == XFER_M2P);
  endfunction

endpackage

// File: rtl/dma_mover_chan.sv
`timescale 1ns/1ps
module dma_mover_chan
  import dma_mover_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [2:0]        sel_i,
  input  logic [31:0]       wdata_i,
  input  logic              preq_i,
  input  logic              busy_i,
  input  logic              cap_i,
  input  logic [31:0]       rdata_i,
  input  logic              beat_done_i,
  output chan_cfg_t         cfg_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [31:0]       buf_o,
  output logic              done_o,
  output logic              elig_o,
  output logic [31:0]       rd_o
);

  chan_cfg_t         cfg_q;
  logic [ADDR_W-1:0] src_q, dst_q, src_step, dst_step;
  logic [CNT_W-1:0]  cnt_q;
  logic [31:0]       buf_q;
  logic              done_q;

  assign src_step = cfg_q.src_hold ? '0 : ADDR_W'(size_step(cfg_q.size));
  assign dst_step = cfg_q.dst_hold ? '0 : ADDR_W'(size_step(cfg_q.size));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      buf_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (wr_i) begin
        case (sel_i)
          SEL_CTRL: cfg_q <= chan_cfg_t'(wdata_i[7:0]);
          SEL_SRC:  src_q <= wdata_i[ADDR_W-1:0];
          SEL_DST:  dst_q <= wdata_i[ADDR_W-1:0];
          SEL_CNT:  cnt_q <= wdata_i[CNT_W-1:0];
          SEL_STAT: if (wdata_i[0]) done_q <= 1'b0;
          default:  ;
        endcase
      end
      if (cap_i) buf_q <= rdata_i & size_mask(cfg_q.size);
      if (beat_done_i) begin
        src_q <= src_q + src_step;
        dst_q <= dst_q + dst_step;
        cnt_q <= cnt_q - CNT_W'(1);
      end
      // completion: idle, enabled, nothing left
      if (cfg_q.en && (cnt_q == '0) && !busy_i) begin
        done_q    <= 1'b1;
        cfg_q.en  <= 1'b0;
      end
    end
  end

  assign elig_o = cfg_q.en && (cnt_q != '0) && (!needs_req(cfg_q.mode) || preq_i);

  always_comb begin
    case (sel_i)
      SEL_CTRL: rd_o = {24'h0, cfg_q};
      SEL_SRC:  rd_o = 32'(src_q);
      SEL_DST:  rd_o = 32'(dst_q);
      SEL_CNT:  rd_o = 32'(cnt_q);
      SEL_STAT: rd_o = {31'h0, done_q};
      default:  rd_o = '0;
    endcase
  end

  assign cfg_o  = cfg_q;
  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign buf_o  = buf_q;
  assign done_o = done_q;

endmodule

// File: rtl/dma_mover_arb.sv
`timescale 1ns/1ps
module dma_mover_arb #(
  parameter int NUM_CH = 9,
  parameter int IDX_W  = 4
) (
  input  logic [NUM_CH-1:0] req_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              any_o
);

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/dma_mover_eng.sv
`timescale 1ns/1ps
module dma_mover_eng
  import dma_mover_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              any_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [31:0]       data_i,
  input  xfer_size_e        size_i,
  input  logic              bus_ack_i,
  output logic [IDX_W-1:0]  cur_o,
  output logic              busy_o,
  output logic              cap_o,
  output logic              beat_done_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [1:0]        bus_size_o,
  output logic [31:0]       bus_wdata_o
);

  eng_state_e       state_q;
  logic [IDX_W-1:0] cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENG_IDLE;
      cur_q   <= '0;
    end else begin
      case (state_q)
        ENG_IDLE: if (any_i) begin
          cur_q   <= idx_i;
          state_q <= ENG_READ;
        end
        ENG_READ:  if (bus_ack_i) state_q <= ENG_WRITE;
        ENG_WRITE: if (bus_ack_i) state_q <= ENG_IDLE;
        default:   state_q <= ENG_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ENG_IDLE);
  assign bus_req_o   = busy_o;
  assign bus_we_o    = (state_q == ENG_WRITE);
  assign bus_addr_o  = bus_we_o ? dst_i : src_i;
  assign bus_size_o  = size_i;
  assign bus_wdata_o = data_i;
  assign cap_o       = (state_q == ENG_READ) && bus_ack_i;
  assign beat_done_o = (state_q == ENG_WRITE) && bus_ack_i;
  assign cur_o       = cur_q;

endmodule

// File: rtl/dma_mover.sv
`timescale 1ns/1ps
module dma_mover
  import dma_mover_pkg::*;
#(
  parameter int NUM_CH = 9,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int REG_AW = CH_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [NUM_CH-1:0] periph_req_i,
  output logic [NUM_CH-1:0] periph_ack_o,
  output logic [NUM_CH-1:0] irq_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [1:0]        bus_size_o,
  output logic [31:0]       bus_wdata_o,
  input  logic [31:0]       bus_rdata_i,
  input  logic              bus_ack_i
);

  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  logic [CH_W-1:0]   reg_ch;
  logic [2:0]        reg_sel;
  chan_cfg_t         cfg_a [NUM_CH];
  logic [ADDR_W-1:0] src_a [NUM_CH];
  logic [ADDR_W-1:0] dst_a [NUM_CH];
  logic [31:0]       buf_a [NUM_CH];
  logic [31:0]       rd_a  [NUM_CH];
  logic [NUM_CH-1:0] elig_v, done_v, en_v;
  logic [CH_W-1:0]   arb_idx, cur_ch;
  logic              arb_any, eng_busy, eng_cap, beat_done;

  assign reg_ch  = reg_addr_i[REG_AW-1:3];
  assign reg_sel = reg_addr_i[2:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic is_cur;
    assign is_cur = (cur_ch == CH_W'(g));

    dma_mover_chan #(
      .ADDR_W(ADDR_W),
      .CNT_W (CNT_W)
    ) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (reg_we_i && (reg_ch == CH_W'(g))),
      .sel_i      (reg_sel),
      .wdata_i    (reg_wdata_i),
      .preq_i     (periph_req_i[g]),
      .busy_i     (eng_busy && is_cur),
      .cap_i      (eng_cap && is_cur),
      .rdata_i    (bus_rdata_i),
      .beat_done_i(beat_done && is_cur),
      .cfg_o      (cfg_a[g]),
      .src_o      (src_a[g]),
      .dst_o      (dst_a[g]),
      .buf_o      (buf_a[g]),
      .done_o     (done_v[g]),
      .elig_o     (elig_v[g]),
      .rd_o       (rd_a[g])
    );

    assign en_v[g]         = cfg_a[g].en;
    assign irq_o[g]        = done_v[g] && cfg_a[g].irq_en;
    assign periph_ack_o[g] = beat_done && is_cur && needs_req(cfg_a[g].mode);
  end

  assign reg_rdata_o = (reg_ch <= LAST_CH) ? rd_a[reg_ch] : '0;

  dma_mover_arb #(
    .NUM_CH(NUM_CH),
    .IDX_W (CH_W)
  ) u_arb (
    .req_i(elig_v),
    .idx_o(arb_idx),
    .any_o(arb_any)
  );

  dma_mover_eng #(
    .ADDR_W(ADDR_W),
    .IDX_W (CH_W)
  ) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .any_i      (arb_any),
    .idx_i      (arb_idx),
    .src_i      (src_a[cur_ch]),
    .dst_i      (dst_a[cur_ch]),
    .data_i     (buf_a[cur_ch]),
    .size_i     (cfg_a[cur_ch].size),
    .bus_ack_i  (bus_ack_i),
    .cur_o      (cur_ch),
    .busy_o     (eng_busy),
    .cap_o      (eng_cap),
    .beat_done_o(beat_done),
    .bus_req_o  (bus_req_o),
    .bus_we_o   (bus_we_o),
    .bus_addr_o (bus_addr_o),
    .bus_size_o (bus_size_o),
    .bus_wdata_o(bus_wdata_o)
  );

endmodule

// File: rtl/dma_mover_chk.sv
`timescale 1ns/1ps
module dma_mover_chk #(
  parameter int NUM_CH = 9,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_i,
  input logic              bus_we_i,
  input logic              bus_ack_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [1:0]        bus_size_i,
  input logic [IDX_W-1:0]  cur_i,
  input logic              busy_i,
  input logic              beat_done_i,
  input logic [NUM_CH-1:0] periph_ack_i,
  input logic [NUM_CH-1:0] done_vec_i,
  input logic [NUM_CH-1:0] en_vec_i
);

  a_r2_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i && !bus_ack_i |=> bus_req_i && $stable(bus_addr_i) && $stable(bus_we_i)
                                && $stable(bus_size_i));

  a_r4_write_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_i && bus_we_i) |-> $past(bus_req_i && bus_ack_i && !bus_we_i));

  a_r5_grant_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !beat_done_i |=> busy_i && $stable(cur_i));

  a_r7_ack_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(periph_ack_i));

  a_r7_ack_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (periph_ack_i != '0) |-> bus_ack_i && bus_we_i && bus_req_i);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_done
    a_r8_done_clears_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(done_vec_i[g]) |-> !en_vec_i[g]);
  end

endmodule

bind dma_mover dma_mover_chk #(
  .NUM_CH(NUM_CH),
  .ADDR_W(ADDR_W),
  .IDX_W (CH_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_i   (bus_req_o),
  .bus_we_i    (bus_we_o),
  .bus_ack_i   (bus_ack_i),
  .bus_addr_i  (bus_addr_o),
  .bus_size_i  (bus_size_o),
  .cur_i       (cur_ch),
  .busy_i      (eng_busy),
  .beat_done_i (beat_done),
  .periph_ack_i(periph_ack_o),
  .done_vec_i  (done_v),
  .en_vec_i    (en_v)
);

// File: tb/test_dma_mover.sv
`timescale 1ns/1ps
module test_dma_mover;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [8:0]  preq = '0;
  logic [8:0]  pack;
  logic [8:0]  irq;
  logic        breq, bwe;
  logic [31:0] baddr, bwdata;
  logic [1:0]  bsize;
  logic [31:0] brdata = '0;
  logic        back = 1'b0;
  logic        init_req = 1'b0;
  logic [7:0]  mem [256];
  int          ack_tot [9];
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  dma_mover i_dma_mover (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .periph_req_i(preq), .periph_ack_o(pack), .irq_o(irq),
    .bus_req_o(breq), .bus_we_o(bwe), .bus_addr_o(baddr), .bus_size_o(bsize),
    .bus_wdata_o(bwdata), .bus_rdata_i(brdata), .bus_ack_i(back)
  );

  function automatic int nb(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [7:0] ival(input int i);
    return 8'(i * 7 + 3);
  endfunction

  // memory model: one-cycle acknowledge
  always @(posedge clk) begin
    if (init_req) for (int i = 0; i < 256; i++) mem[i] <= ival(i);
    if (!rst_n) back <= 1'b0;
    else begin
      back <= breq && !back;
      if (breq && !back) begin
        if (bwe) begin
          for (int k = 0; k < 4; k++)
            if (k < nb(bsize)) mem[baddr[7:0] + 8'(k)] <= bwdata[8*k +: 8];
        end else begin
          brdata <= {mem[baddr[7:0] + 8'd3], mem[baddr[7:0] + 8'd2],
                     mem[baddr[7:0] + 8'd1], mem[baddr[7:0]]};
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) for (int i = 0; i < 9; i++) ack_tot[i] <= ack_tot[i] + int'(pack[i]);
    else for (int i = 0; i < 9; i++) ack_tot[i] <= 0;
  end

  typedef struct packed {
    logic [3:0] ch;
    logic [1:0] size;
    logic       shold;
    logic       dhold;
    logic [7:0] src;
    logic [7:0] dst;
    logic [7:0] cnt;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'd0, 2'd0, 1'b0, 1'b0, 8'h10, 8'h80, 8'd4},
    '{4'd3, 2'd1, 1'b0, 1'b0, 8'h20, 8'h90, 8'd3},
    '{4'd8, 2'd2, 1'b0, 1'b0, 8'h30, 8'ha0, 8'd3},
    '{4'd4, 2'd2, 1'b1, 1'b0, 8'h40, 8'hb0, 8'd2},
    '{4'd6, 2'd0, 1'b0, 1'b1, 8'h50, 8'hc0, 8'd3},
    '{4'd1, 2'd1, 1'b1, 1'b1, 8'h60, 8'hd0, 8'd2}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  task automatic reg_wr(input int ch, input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {4'(ch), sel}; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input int ch, input logic [2:0] sel, output logic [31:0] d);
    @(negedge clk);
    reg_addr = {4'(ch), sel};
    #1 d = reg_rdata;
  endtask

  task automatic wait_irq(input int ch, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (irq[ch]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic init_mem();
    @(negedge clk); init_req = 1'b1;
    @(negedge clk); init_req = 1'b0;
  endtask

  task automatic run_all();
    logic [31:0] d, c1;
    logic [7:0]  exp_mem [256];
    bit ok;
    int bad, a2, a5;

    // reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < 5; s++) begin
      reg_rd(0, 3'(s), d); chk(d == 0, "R1 ch0 reg", d, 0);
      reg_rd(8, 3'(s), d); chk(d == 0, "R1 ch8 reg", d, 0);
    end
    chk(breq == 1'b0, "R1 bus_req", 32'(breq), 0);
    chk(irq == 9'h0, "R1 irq", 32'(irq), 0);

    // R3 control readback and missing channel
    reg_wr(3, 3'd0, 32'hfe);
    reg_rd(3, 3'd0, d); chk(d == 32'hfe, "R3 ctrl readback", d, 32'hfe);
    reg_wr(3, 3'd0, 32'h0);
    reg_rd(12, 3'd1, d); chk(d == 0, "R3 absent channel", d, 0);

    // table of memory-to-memory transfers (R4 R6 R8 R11)
    for (int v = 0; v < 6; v++) begin
      automatic vec_t t = VECS[v];
      automatic int n = nb(t.size);
      automatic logic [7:0] ctrl = {1'b1, t.dhold, t.shold, t.size, 2'b00, 1'b1};
      init_mem();
      for (int i = 0; i < 256; i++) exp_mem[i] = ival(i);
      for (int b = 0; b < int'(t.cnt); b++) begin
        automatic int sa = int'(t.src) + (t.shold ? 0 : b * n);
        automatic int da = int'(t.dst) + (t.dhold ? 0 : b * n);
        for (int k = 0; k < n; k++) exp_mem[8'(da + k)] = exp_mem[8'(sa + k)];
      end
      reg_wr(t.ch, 3'd1, 32'(t.src));
      reg_wr(t.ch, 3'd2, 32'(t.dst));
      reg_wr(t.ch, 3'd3, 32'(t.cnt));
      reg_wr(t.ch, 3'd0, 32'(ctrl));
      wait_irq(t.ch, ok);
      chk(ok, "R8 completion irq", 32'(ok), 1);
      bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad++;
      chk(bad == 0, "R4 memory image mismatches", bad, 0);
      reg_rd(t.ch, 3'd1, d);
      chk(d == 32'(t.src) + (t.shold ? 0 : 32'(int'(t.cnt) * n)), "R6 R11 final source", d,
          32'(t.src) + (t.shold ? 0 : 32'(int'(t.cnt) * n)));
      reg_rd(t.ch, 3'd2, d);
      chk(d == 32'(t.dst) + (t.dhold ? 0 : 32'(int'(t.cnt) * n)), "R6 R11 final dest", d,
          32'(t.dst) + (t.dhold ? 0 : 32'(int'(t.cnt) * n)));
      reg_rd(t.ch, 3'd3, d); chk(d == 0, "R11 final count", d, 0);
      reg_rd(t.ch, 3'd0, d); chk(d == 32'(ctrl & 8'hfe), "R8 enable cleared", d, 32'(ctrl & 8'hfe));
      reg_rd(t.ch, 3'd4, d); chk(d == 1, "R8 done set", d, 1);
      reg_wr(t.ch, 3'd4, 32'h1);
      #1 chk(irq[t.ch] == 1'b0, "R10 irq cleared", 32'(irq[t.ch]), 0);
    end

    // priority and peripheral gating (R5 R7 R2)
    init_mem();
    reg_wr(5, 3'd1, 32'h10); reg_wr(5, 3'd2, 32'h80); reg_wr(5, 3'd3, 32'd1);
    reg_wr(2, 3'd1, 32'h20); reg_wr(2, 3'd2, 32'h90); reg_wr(2, 3'd3, 32'd1);
    reg_wr(5, 3'd0, 32'h83);
    reg_wr(2, 3'd0, 32'h83);
    repeat (6) @(negedge clk);
    chk(breq == 1'b0, "R7 no beat without request", 32'(breq), 0);
    a2 = ack_tot[2]; a5 = ack_tot[5];
    preq = 9'b0_0010_0100;
    @(negedge clk);
    chk(breq && !bwe && baddr == 32'h20, "R5 lowest index first", baddr, 32'h20);
    @(negedge clk);
    chk(breq && back && baddr == 32'h20 && !bwe, "R2 request held to ack", baddr, 32'h20);
    wait_irq(2, ok); chk(ok, "R7 ch2 done", 32'(ok), 1);
    wait_irq(5, ok); chk(ok, "R7 ch5 done", 32'(ok), 1);
    preq = '0;
    chk(mem[8'h90] == ival(8'h20), "R4 ch2 data", 32'(mem[8'h90]), 32'(ival(8'h20)));
    chk(mem[8'h80] == ival(8'h10), "R4 ch5 data", 32'(mem[8'h80]), 32'(ival(8'h10)));
    chk(ack_tot[2] - a2 == 1, "R7 ch2 ack pulses", ack_tot[2] - a2, 1);
    chk(ack_tot[5] - a5 == 1, "R7 ch5 ack pulses", ack_tot[5] - a5, 1);
    reg_wr(2, 3'd4, 32'h1); reg_wr(5, 3'd4, 32'h1);

    // disable mid-transfer (R9)
    init_mem();
    reg_wr(7, 3'd1, 32'h00); reg_wr(7, 3'd2, 32'h80); reg_wr(7, 3'd3, 32'd20);
    reg_wr(7, 3'd0, 32'h81);
    repeat (12) @(negedge clk);
    reg_wr(7, 3'd0, 32'h80);
    repeat (20) @(negedge clk);
    chk(breq == 1'b0, "R9 bus idle after disable", 32'(breq), 0);
    reg_rd(7, 3'd3, c1);
    chk(c1 > 0 && c1 < 20, "R9 count partially used", c1, 10);
    repeat (20) @(negedge clk);
    reg_rd(7, 3'd3, d); chk(d == c1, "R9 count frozen", d, c1);
    reg_rd(7, 3'd4, d); chk(d == 0, "R9 done stays low", d, 0);
    chk(irq[7] == 1'b0, "R9 no irq", 32'(irq[7]), 0);

    // zero count, W1C, irq gating (R8 R10)
    reg_wr(0, 3'd3, 32'd0);
    reg_wr(0, 3'd0, 32'h81);
    @(negedge clk);
    chk(irq[0] == 1'b1, "R8 zero count completes", 32'(irq[0]), 1);
    reg_rd(0, 3'd0, d); chk(d == 32'h80, "R8 zero count clears enable", d, 32'h80);
    reg_wr(0, 3'd4, 32'h0);
    reg_rd(0, 3'd4, d); chk(d == 1, "R10 write 0 keeps done", d, 1);
    reg_wr(0, 3'd4, 32'h1);
    reg_rd(0, 3'd4, d); chk(d == 0, "R10 write 1 clears done", d, 0);
    chk(irq[0] == 1'b0, "R10 irq low after clear", 32'(irq[0]), 0);
    reg_wr(1, 3'd3, 32'd0);
    reg_wr(1, 3'd0, 32'h01);
    @(negedge clk);
    reg_rd(1, 3'd4, d); chk(d == 1, "R10 done without irq enable", d, 1);
    chk(irq[1] == 1'b0, "R10 irq masked", 32'(irq[1]), 0);
  endtask

  initial begin
    bit wd = 1'b0;
    fork
      run_all();
      begin repeat (150000) @(posedge clk); wd = 1'b1; end
    join_any
    disable fork;
    if (wd) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule